// File: doc/BRIEF.md
# Echo Region Fill Engine

This block works out where the echo scratch area of the sound generator sits in the 64 KB sample RAM. It does this from three 8-bit configuration values: a flag byte, a start page and a length in 2 KB units. On request it overwrites that whole area with 0xFF, one byte per clock, through a plain RAM write port. A busy level and a one-cycle done pulse tell the requester when the wipe has finished. The write sequence never runs past the last RAM address. When the area would extend beyond 0xFFFF, the fill ends at 0xFFFF and does not wrap to address 0.

Alongside the fill, a monitor watches the CPU address bus. It raises a sticky flag when any valid CPU access lands inside the live echo area. Software-side tooling can use the flag to learn that the CPU has touched memory the echo hardware also owns. The flag stays set until a dedicated clear input drops it.

The fill sequencer is a three-state machine:
- IDLE waits for a start pulse.
- IDLE→FILL is taken on a start pulse when the area is non-empty.
- IDLE→FINISH is taken on a start pulse when the area is disabled or has zero length.
- FILL→FILL steps the address after each write.
- FILL→FINISH is taken on the last write.
- FINISH→IDLE is taken unconditionally after the one-cycle done pulse.

Top module: `echo_region_filler`

## Requirements
- R1: After reset, mem_we, fill_busy, fill_done and echo_touch are all 0.
- R2: A start pulse with flag bit 5 equal to 0 and a non-zero length writes 0xFF to consecutive ascending addresses. The first address is start_page*0x100, one write is made per cycle, and there are length*0x800 writes. The first write is in the cycle after the start pulse.
- R3: When start_page*0x100 + length*0x800 exceeds 0x10000, the writes stop after address 0xFFFF and never wrap to low addresses.
- R4: fill_busy is high in exactly the write cycles. fill_done is high for one cycle, in the cycle right after the last write, and is low in the cycle after that.
- R5: A start pulse while flag bit 5 is 1, or while the length is 0, produces no write. fill_done pulses in the cycle after the start pulse and fill_busy stays low.
- R6: A start pulse that arrives while a fill is running has no effect. That fill continues unchanged, and no new fill follows it.
- R7: The area is captured at the start pulse. Changing the configuration inputs during a fill does not change its addresses or its write count.
- R8: A cycle with cpu_valid high and cpu_addr in [start_page*0x100, start_page*0x100 + length*0x800), with flag bit 5 equal to 0, sets echo_touch from the next cycle on. The flag then stays set.
- R9: A CPU access outside that range, any access while flag bit 5 is 1, and any address while cpu_valid is low leave echo_touch unchanged.
- R10: touch_clr clears echo_touch in the next cycle. If an in-range access comes in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flags | input | 8 | Flag byte; bit 5 high disables the echo area |
| cfg_page | input | 8 | Start page of the echo area (256-byte units) |
| cfg_len | input | 8 | Length of the echo area (2 KB units) |
| fill_go | input | 1 | One-cycle request to wipe the area |
| mem_addr | output | 16 | RAM write address |
| mem_wdata | output | 8 | RAM write data (always 0xFF) |
| mem_we | output | 1 | RAM write enable |
| fill_busy | output | 1 | High while writes are being issued |
| fill_done | output | 1 | One-cycle completion pulse |
| cpu_addr | input | 16 | CPU bus address being monitored |
| cpu_valid | input | 1 | CPU access qualifier |
| touch_clr | input | 1 | Clears the sticky access flag |
| echo_touch | output | 1 | Sticky flag: CPU accessed the echo area |

## Verification
A stuck or mis-stepped address register shows at mem_addr within one write cycle as a gap, a repeat or a wrap. A wrong stop value shows as a write count that is off when fill_done arrives. A sequencer that leaves FILL too early or too late moves the done pulse away from the cycle after the last write. A state machine that listens to start while busy shows a second burst right after done. An error in the monitor's range compare shows as echo_touch set, or not set, in the cycle after one probe at a region edge. Directed probes at base-1, base, top-1 and top expose an off-by-one at once.

// File: rtl/echo_fill_pkg.sv
package echo_fill_pkg;
    // Geometry of the echo area and the RAM it lives in
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int CFG_W      = 8;
    localparam int PAGE_SHIFT = 8;
    localparam int LEN_SHIFT  = 11;
    localparam int DIS_BIT    = 5;
    localparam logic [DATA_W-1:0] WIPE_VALUE = '1;

    // Wide enough to hold base + length without overflow
    localparam int LEN_SPAN = CFG_W + LEN_SHIFT;
    localparam int SPAN_W   = ((LEN_SPAN > ADDR_W) ? LEN_SPAN : ADDR_W) + 1;

    typedef logic [SPAN_W-1:0] span_t;

    typedef struct packed {
        logic  active;
        logic  empty;
        span_t base;
        span_t top;
        span_t stop;
    } region_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_FINISH = 2'd2
    } fill_state_t;
endpackage

// File: rtl/echo_region_decode.sv
module echo_region_decode
    import echo_fill_pkg::*;
(
    input  logic [CFG_W-1:0] flags,
    input  logic [CFG_W-1:0] page,
    input  logic [CFG_W-1:0] len,
    output region_t          region
);
    localparam span_t MEM_TOP = span_t'(1) << ADDR_W;

    span_t base_w;
    span_t length_w;
    span_t top_w;

    always_comb begin
        base_w   = span_t'(page) << PAGE_SHIFT;
        length_w = span_t'(len) << LEN_SHIFT;
        top_w    = base_w + length_w;

        region.active = ~flags[DIS_BIT];
        region.empty  = flags[DIS_BIT] | (len == '0);
        region.base   = base_w;
        region.top    = top_w;
        region.stop   = (top_w > MEM_TOP) ? MEM_TOP : top_w;
    end
endmodule

// File: rtl/echo_fill_fsm.sv
module echo_fill_fsm
    import echo_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  region_t           region,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              busy,
    output logic              done
);
    fill_state_t state_q, state_d;
    span_t       cur_q, cur_d;
    span_t       stop_q, stop_d;
    logic        last_wr;

    assign last_wr = ((cur_q + span_t'(1)) == stop_q);

    // Next-state and datapath update
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        stop_d  = stop_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    cur_d  = region.base;
                    stop_d = region.stop;
                    state_d = region.empty ? ST_FINISH : ST_FILL;
                end
            end
            ST_FILL: begin
                cur_d = cur_q + span_t'(1);
                if (last_wr) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            stop_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            stop_q  <= stop_d;
        end
    end

    // Outputs
    always_comb begin
        wr_addr = cur_q[ADDR_W-1:0];
        wr_data = WIPE_VALUE;
        wr_en   = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FILL: begin
                wr_en = 1'b1;
                busy  = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    // R3
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr > $past(wr_addr)));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !wr_en));

    // R6
    go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go && !last_wr) |=> busy);
endmodule

// File: rtl/echo_touch_monitor.sv
module echo_touch_monitor
    import echo_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  region_t           region,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_valid,
    input  logic              clr,
    output logic              touch
);
    span_t probe;
    logic  hit_now;

    always_comb begin
        probe   = span_t'(cpu_addr);
        hit_now = cpu_valid && region.active &&
                  (probe >= region.base) && (probe < region.top);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            touch <= 1'b0;
        end else if (hit_now) begin
            touch <= 1'b1;
        end else if (clr) begin
            touch <= 1'b0;
        end
    end

    // R8
    touch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_now |=> touch);

    // R8
    touch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && !clr) |=> touch);

    // R10
    touch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit_now) |=> !touch);
endmodule

// File: rtl/echo_region_filler.sv
module echo_region_filler
    import echo_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_flags,
    input  logic [CFG_W-1:0]  cfg_page,
    input  logic [CFG_W-1:0]  cfg_len,
    input  logic              fill_go,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              fill_busy,
    output logic              fill_done,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_valid,
    input  logic              touch_clr,
    output logic              echo_touch
);
    region_t region;

    echo_region_decode u_decode (
        .flags  (cfg_flags),
        .page   (cfg_page),
        .len    (cfg_len),
        .region (region)
    );

    echo_fill_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (fill_go),
        .region  (region),
        .wr_addr (mem_addr),
        .wr_data (mem_wdata),
        .wr_en   (mem_we),
        .busy    (fill_busy),
        .done    (fill_done)
    );

    echo_touch_monitor u_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .region    (region),
        .cpu_addr  (cpu_addr),
        .cpu_valid (cpu_valid),
        .clr       (touch_clr),
        .touch     (echo_touch)
    );

    // R4
    busy_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> (mem_we && mem_wdata == WIPE_VALUE));
endmodule

// File: tb/echo_region_filler_tb.sv
module echo_region_filler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_flags = 8'h00;
    logic [7:0]  cfg_page = 8'h00;
    logic [7:0]  cfg_len = 8'h00;
    logic        fill_go = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        fill_busy;
    logic        fill_done;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_valid = 1'b0;
    logic        touch_clr = 1'b0;
    logic        echo_touch;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    echo_region_filler u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_flags(cfg_flags), .cfg_page(cfg_page), .cfg_len(cfg_len),
        .fill_go(fill_go),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .fill_busy(fill_busy), .fill_done(fill_done),
        .cpu_addr(cpu_addr), .cpu_valid(cpu_valid),
        .touch_clr(touch_clr), .echo_touch(echo_touch)
    );

    function automatic int exp_count(input logic [7:0] f, input logic [7:0] p, input logic [7:0] l);
        int b, t;
        if (f[5] || l == 0) return 0;
        b = int'(p) * 256;
        t = b + int'(l) * 2048;
        if (t > 65536) t = 65536;
        return t - b;
    endfunction

    function automatic bit exp_hit(input logic [7:0] f, input logic [7:0] p, input logic [7:0] l,
                                   input logic [15:0] a, input bit v);
        int b, t;
        b = int'(p) * 256;
        t = b + int'(l) * 2048;
        return v && !f[5] && (int'(a) >= b) && (int'(a) < t);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_fill(input logic [7:0] f, input logic [7:0] p, input logic [7:0] l,
                            input bit disturb, input string req);
        int n, base, writes, bad, first_bad;
        bit done_seen, busy_at_done, kicked;
        n = exp_count(f, p, l);
        base = int'(p) * 256;
        writes = 0; bad = 0; first_bad = -1;
        done_seen = 0; busy_at_done = 0; kicked = 0;
        @(negedge clk);
        cfg_flags = f; cfg_page = p; cfg_len = l; fill_go = 1'b1;
        @(negedge clk);
        fill_go = 1'b0;
        for (int cyc = 0; cyc < n + 4; cyc++) begin
            if (mem_we) begin
                if (mem_addr != 16'(base + writes) || mem_wdata != 8'hFF ||
                    !fill_busy || fill_done) begin
                    bad++;
                    if (first_bad < 0) first_bad = int'(mem_addr);
                end
                writes++;
            end else begin
                done_seen = fill_done;
                busy_at_done = fill_busy;
                break;
            end
            if (disturb && writes == 5 && !kicked) begin
                // R6, R7: new configuration and a start pulse mid-fill
                cfg_flags = 8'h00; cfg_page = 8'h00; cfg_len = 8'h01;
                fill_go = 1'b1;
                kicked = 1;
            end else begin
                fill_go = 1'b0;
            end
            @(negedge clk);
        end
        fill_go = 1'b0;
        check(writes == n, {req, " write count"}, writes, n);
        check(bad == 0, {req, " address/data sequence"}, first_bad, base);
        check(done_seen && !busy_at_done, "R4 done after last write", int'(done_seen), 1);
        @(negedge clk);
        check(!fill_done && !fill_busy && !mem_we,
              disturb ? "R6 no restart after fill" : "R4 single done pulse",
              int'({fill_done, fill_busy, mem_we}), 0);
    endtask

    task automatic probe(input logic [7:0] f, input logic [7:0] p, input logic [7:0] l,
                         input logic [15:0] a, input bit v, input string req);
        bit e;
        @(negedge clk);
        touch_clr = 1'b1; cpu_valid = 1'b0;
        @(negedge clk);
        touch_clr = 1'b0;
        check(!echo_touch, "R10 clear", int'(echo_touch), 0);
        cfg_flags = f; cfg_page = p; cfg_len = l;
        cpu_addr = a; cpu_valid = v;
        e = exp_hit(f, p, l, a, v);
        @(negedge clk);
        cpu_valid = 1'b0;
        check(echo_touch == e, req, int'(echo_touch), int'(e));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        // R1
        check(!mem_we && !fill_busy && !fill_done && !echo_touch, "R1 reset outputs",
              int'({mem_we, fill_busy, fill_done, echo_touch}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_fill(8'h00, 8'h10, 8'h01, 0, "R2 plain fill");
        run_fill(8'hDF, 8'h23, 8'h02, 0, "R2 other flag bits");
        run_fill(8'h00, 8'hF8, 8'h01, 0, "R3 ends exactly at top");
        run_fill(8'h00, 8'hFC, 8'h01, 0, "R3 clipped fill");
        run_fill(8'h00, 8'hFF, 8'h03, 0, "R3 clipped last page");
        run_fill(8'h20, 8'h40, 8'h02, 0, "R5 disabled area");
        run_fill(8'h00, 8'h40, 8'h00, 0, "R5 zero length");
        run_fill(8'h00, 8'h80, 8'h01, 1, "R7 config change mid-fill");

        for (int i = 0; i < 6; i++) begin
            logic [7:0] f, p, l;
            f = 8'($urandom());
            p = 8'($urandom());
            l = 8'($urandom_range(0, 2));
            run_fill(f, p, l, 0, "R2 random fill");
        end

        // Access monitor: directed edges
        probe(8'h00, 8'h30, 8'h02, 16'h2FFF, 1, "R9 below base");
        probe(8'h00, 8'h30, 8'h02, 16'h3000, 1, "R8 at base");
        probe(8'h00, 8'h30, 8'h02, 16'h3FFF, 1, "R8 last byte");
        probe(8'h00, 8'h30, 8'h02, 16'h4000, 1, "R9 at top");
        probe(8'h20, 8'h30, 8'h02, 16'h3100, 1, "R9 disabled");
        probe(8'h00, 8'h30, 8'h02, 16'h3100, 0, "R9 not valid");
        probe(8'h00, 8'hF0, 8'h08, 16'h0100, 1, "R9 no wrap in compare");

        for (int i = 0; i < 40; i++) begin
            logic [7:0] f, p, l;
            logic [15:0] a;
            f = 8'($urandom()) & 8'h2F;
            p = 8'($urandom());
            l = 8'($urandom_range(0, 4));
            a = {p, 8'h00} + 16'($urandom_range(0, 12000)) - 16'd100;
            probe(f, p, l, a, 1'($urandom()), "R8 random probe");
        end

        // R8 sticky, R10 set wins over clear
        probe(8'h00, 8'h30, 8'h02, 16'h3000, 1, "R8 set before sticky test");
        @(negedge clk);
        cpu_addr = 16'h0000; cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
        check(echo_touch, "R8 sticky after miss", int'(echo_touch), 1);
        touch_clr = 1'b1; cpu_addr = 16'h3005; cpu_valid = 1'b1;
        @(negedge clk);
        touch_clr = 1'b0; cpu_valid = 1'b0;
        check(echo_touch, "R10 set wins", int'(echo_touch), 1);
        touch_clr = 1'b1;
        @(negedge clk);
        touch_clr = 1'b0;
        check(!echo_touch, "R10 clear alone", int'(echo_touch), 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule